// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block is the control state machine that runs DDR3 write-leveling training on one memory channel. A one-cycle start pulse begins a channel run. The block sets the channel into a training-safe condition: refresh is suppressed and the short ZQ calibration interval is forced to zero. It then walks the chip-select groups in ascending order. For every populated group it trains the matching DIMM in one or two nibble passes.

Each nibble pass has a fixed order. First, mode-register writes with write-leveling turned on go to every present chip select. Next comes a load of the target DIMM's leveling termination value and a settling wait. After that the sequencer requests seed programming, raises the leveling termination enable, and pulses the PHY training enable for a fixed window. It then hands the captured delays to a result-recovery block and waits with termination off. After the last nibble, the mode registers are rewritten with leveling turned off. When every group has been handled, refresh and the normal ZQ interval are restored and a one-cycle done pulse is raised.

A run can be flagged as the second, higher-speed pass. Such a run is dropped at once and reported as complete unless the current memory speed is above the start-up speed. The mode-register port, the seed programmer and the result-recovery block each connect through request/acknowledge handshakes.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, busy_o, done_o, mr_req_o, seed_req_o, post_req_o, odt_en_o, train_en_o, odt_load_o and refresh_off_o are 0, and zq_int_o is 2.
- R2: If start_i arrives with second_pass_i = 1 and cur_speed_i <= boot_speed_i, done_o is 1 in the cycle after start_i is sampled. busy_o stays 0, and no request or training output is raised. With cur_speed_i > boot_speed_i the run proceeds normally.
- R3: Chip selects are walked in ascending order with a step of 2 when pair_cs_i = 1 and 1 otherwise. A group at chip select c is trained only if cs_enable_i has a set bit under mask 3<<c (step 2) or 1<<c (step 1). Its DIMM index dimm_o is c divided by the step.
- R4: At each mode-register block, every chip select with cs_present_i set gets, in ascending order, an MR1 write (mr_sel_o = 0) and then an MR2 write (mr_sel_o = 1). mr_cs_o names the chip select. A request is held with stable fields until mr_ack_i is seen.
- R5: odt_load_o pulses in the cycle after the final acknowledge of a leveling-on block. seed_req_o then rises exactly 41 cycles after that pulse, which leaves 40 wait cycles.
- R6: seed_req_o is held until seed_ack_i. odt_en_o rises in the next cycle, and train_en_o rises 10 cycles after odt_en_o. train_en_o stays high for exactly 200 cycles, and only while odt_en_o is high.
- R7: In the cycle train_en_o falls, post_req_o rises with odt_en_o still high. post_req_o is held until post_ack_i.
- R8: odt_en_o falls in the cycle after the post acknowledge. It stays low for exactly 10 cycles before the next mode-register request rises.
- R9: With per_nibble_i = 1 each DIMM gets nibble passes 0 then 1 (nibble_o); with 0 it gets only nibble 0. All passes use mr_wl_o = 1. After the last pass one more mode-register block runs with mr_wl_o = 0.
- R10: From the cycle after an accepted start until the done cycle, busy_o and refresh_off_o are 1 and zq_int_o is 0. In the done cycle and while idle, refresh_off_o is 0 and zq_int_o is 2.
- R11: done_o is a single-cycle pulse with busy_o low. It comes after the last group is scanned. A start_i pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a channel run (pulse) |
| second_pass_i | input | 1 | Run is the higher-speed pass |
| cur_speed_i | input | SPD_W | Current memory speed code |
| boot_speed_i | input | SPD_W | Start-up speed code |
| pair_cs_i | input | 1 | 1: two chip selects share a delay set |
| per_nibble_i | input | 1 | 1: train each nibble separately |
| cs_enable_i | input | CS_NUM | Enabled chip selects |
| cs_present_i | input | CS_NUM | Present chip selects (receive mode writes) |
| mr_req_o | output | 1 | Mode-register write request |
| mr_cs_o | output | CS_W | Chip select of the write |
| mr_sel_o | output | 1 | 0: MR1, 1: MR2 |
| mr_wl_o | output | 1 | Leveling mode bit for the write |
| mr_ack_i | input | 1 | Mode-register write accepted |
| odt_load_o | output | 1 | Load leveling termination value of dimm_o |
| seed_req_o | output | 1 | Seed programming request |
| seed_ack_i | input | 1 | Seeds loaded |
| odt_en_o | output | 1 | Leveling termination enable |
| train_en_o | output | 1 | PHY training enable |
| post_req_o | output | 1 | Result recovery request |
| post_ack_i | input | 1 | Results processed |
| dimm_o | output | DIMM_W | Target DIMM index |
| nibble_o | output | 1 | Current nibble pass |
| refresh_off_o | output | 1 | Auto-refresh suppressed |
| zq_int_o | output | 2 | Short ZQ calibration interval code |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete (pulse) |

## Verification
The reference model in the bench expects every mode-register write, seed request and post request as a queued token, built from the group mask rules. It compares each token at the cycle its handshake completes. The timing results are due at fixed offsets. The termination enable follows a seed handshake by one cycle, and a termination fall follows a post handshake by one cycle. The seed request comes 41 cycles after the load pulse. The training enable comes 10 cycles after the termination enable and lasts 200 cycles, and the next mode-register request comes 10 cycles after termination drops. These offsets are measured with cycle stamps taken at each falling edge, so every output is sampled half a period after the edge that set it. The done pulse is checked one cycle after start on a skipped pass. In a normal run the bench polls for it and then confirms that it drops in the following cycle.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_MR1, ST_MR2, ST_ODT_LOAD, ST_MR_WAIT,
    ST_SEED, ST_ODT_SET, ST_TRAIN, ST_POST, ST_ODT_OFF, ST_DONE
  } wl_state_e;

  localparam logic [1:0] ZQ_HOLD   = 2'd0;
  localparam logic [1:0] ZQ_NORMAL = 2'd2;

  // A group is live when any enable bit under its mask is set.
  function automatic logic grp_live(input logic [31:0] en, input int unsigned cs,
                                    input logic pair);
    logic [31:0] mask;
    mask = pair ? 32'h3 : 32'h1;
    return |(en & (mask << cs));
  endfunction

  // DIMM index of a chip-select group.
  function automatic int unsigned grp_dimm(input int unsigned cs, input logic pair);
    return pair ? (cs >> 1) : cs;
  endfunction

  // A run proceeds unless it is a second pass that would not raise speed.
  function automatic logic run_due(input logic second, input logic [15:0] cur,
                                   input logic [15:0] boot);
    return !second || (cur > boot);
  endfunction

endpackage

// File: rtl/wlvl_timer.sv
module wlvl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/wlvl_grp_sel.sv
module wlvl_grp_sel
  import wlvl_pkg::*;
#(
  parameter int CS_NUM = 8,
  parameter int CS_W   = $clog2(CS_NUM),
  parameter int DIMM_W = CS_W
) (
  input  logic [CS_NUM-1:0] cs_en,
  input  logic [CS_W:0]     cs_ptr,
  input  logic              pair,
  output logic              live,
  output logic              past_end,
  output logic [DIMM_W-1:0] dimm,
  output logic [CS_W:0]     next_ptr
);
  assign past_end = (32'(cs_ptr) >= CS_NUM);
  assign live     = grp_live(32'(cs_en), 32'(cs_ptr), pair);
  assign dimm     = DIMM_W'(grp_dimm(32'(cs_ptr), pair));
  assign next_ptr = cs_ptr + (pair ? (CS_W+1)'(2) : (CS_W+1)'(1));
endmodule

// File: rtl/wlvl_next_present.sv
module wlvl_next_present #(
  parameter int CS_NUM = 8,
  parameter int CS_W   = $clog2(CS_NUM)
) (
  input  logic [CS_NUM-1:0] present,
  input  logic [CS_W:0]     from,
  output logic              found,
  output logic [CS_W-1:0]   idx
);
  logic [CS_NUM-1:0] hit;

  for (genvar g = 0; g < CS_NUM; g++) begin : g_hit
    assign hit[g] = present[g] && (from <= (CS_W+1)'(g));
  end

  always_comb begin
    idx = '0;
    for (int i = CS_NUM - 1; i >= 0; i--) begin
      if (hit[i]) idx = CS_W'(i);
    end
  end

  assign found = |hit;
endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
  import wlvl_pkg::*;
#(
  parameter int CS_NUM     = 8,
  parameter int SPD_W      = 4,
  parameter int MR_WAIT    = 40,
  parameter int ODT_WAIT   = 10,
  parameter int TRAIN_WAIT = 200,
  parameter int CS_W       = $clog2(CS_NUM),
  parameter int DIMM_W     = CS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              second_pass_i,
  input  logic [SPD_W-1:0]  cur_speed_i,
  input  logic [SPD_W-1:0]  boot_speed_i,
  input  logic              pair_cs_i,
  input  logic              per_nibble_i,
  input  logic [CS_NUM-1:0] cs_enable_i,
  input  logic [CS_NUM-1:0] cs_present_i,
  output logic              mr_req_o,
  output logic [CS_W-1:0]   mr_cs_o,
  output logic              mr_sel_o,
  output logic              mr_wl_o,
  input  logic              mr_ack_i,
  output logic              odt_load_o,
  output logic              seed_req_o,
  input  logic              seed_ack_i,
  output logic              odt_en_o,
  output logic              train_en_o,
  output logic              post_req_o,
  input  logic              post_ack_i,
  output logic [DIMM_W-1:0] dimm_o,
  output logic              nibble_o,
  output logic              refresh_off_o,
  output logic [1:0]        zq_int_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_A   = (MR_WAIT > ODT_WAIT) ? MR_WAIT : ODT_WAIT;
  localparam int TMR_MAX = (TRAIN_WAIT > MAX_A) ? TRAIN_WAIT : MAX_A;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  wl_state_e         state, st_n;
  logic [CS_W:0]     cs_ptr, cs_n;
  logic [CS_W-1:0]   mr_ptr, mr_n;
  logic [DIMM_W-1:0] dimm_q, dimm_n;
  logic              nib_q, nib_n, wl_q, wl_n, ref_q, ref_n;
  logic              pair_q, pair_n, pn_q, pn_n;

  // Internal events, named for the checker and waveform reading.
  logic              tmr_load, tmr_expired, mr_enter, run_ok;
  logic [TMR_W-1:0]  tmr_val;
  logic              grp_ok, grp_end, np_found;
  logic [DIMM_W-1:0] grp_idx;
  logic [CS_W:0]     grp_next, np_from;
  logic [CS_W-1:0]   np_idx;

  wlvl_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  wlvl_grp_sel #(.CS_NUM(CS_NUM), .CS_W(CS_W), .DIMM_W(DIMM_W)) u_grp (
    .cs_en(cs_enable_i), .cs_ptr(cs_ptr), .pair(pair_q), .live(grp_ok),
    .past_end(grp_end), .dimm(grp_idx), .next_ptr(grp_next)
  );

  assign np_from = (state == ST_MR2) ? ({1'b0, mr_ptr} + (CS_W+1)'(1)) : '0;

  wlvl_next_present #(.CS_NUM(CS_NUM), .CS_W(CS_W)) u_np (
    .present(cs_present_i), .from(np_from), .found(np_found), .idx(np_idx)
  );

  assign run_ok = run_due(second_pass_i, 16'(cur_speed_i), 16'(boot_speed_i));

  always_comb begin
    st_n = state; cs_n = cs_ptr; mr_n = mr_ptr; dimm_n = dimm_q;
    nib_n = nib_q; wl_n = wl_q; ref_n = ref_q; pair_n = pair_q; pn_n = pn_q;
    tmr_load = 1'b0; tmr_val = '0; mr_enter = 1'b0;
    unique case (state)
      ST_IDLE: if (start_i) begin
        pair_n = pair_cs_i;
        pn_n   = per_nibble_i;
        if (run_ok) begin
          ref_n = 1'b1; cs_n = '0; st_n = ST_SCAN;
        end else begin
          st_n = ST_DONE;
        end
      end
      ST_SCAN: begin
        if (grp_end) begin
          ref_n = 1'b0; st_n = ST_DONE;
        end else if (grp_ok) begin
          dimm_n = grp_idx; nib_n = 1'b0; wl_n = 1'b1; mr_enter = 1'b1;
        end else begin
          cs_n = grp_next;
        end
      end
      ST_MR1:   if (mr_ack_i) st_n = ST_MR2;
      ST_MR2:   if (mr_ack_i) mr_enter = 1'b1;
      ST_ODT_LOAD: begin
        st_n = ST_MR_WAIT; tmr_load = 1'b1; tmr_val = TMR_W'(MR_WAIT - 1);
      end
      ST_MR_WAIT: if (tmr_expired) st_n = ST_SEED;
      ST_SEED: if (seed_ack_i) begin
        st_n = ST_ODT_SET; tmr_load = 1'b1; tmr_val = TMR_W'(ODT_WAIT - 1);
      end
      ST_ODT_SET: if (tmr_expired) begin
        st_n = ST_TRAIN; tmr_load = 1'b1; tmr_val = TMR_W'(TRAIN_WAIT - 1);
      end
      ST_TRAIN: if (tmr_expired) st_n = ST_POST;
      ST_POST: if (post_ack_i) begin
        st_n = ST_ODT_OFF; tmr_load = 1'b1; tmr_val = TMR_W'(ODT_WAIT - 1);
      end
      ST_ODT_OFF: if (tmr_expired) begin
        if (pn_q && !nib_q) nib_n = 1'b1;
        else                wl_n  = 1'b0;
        mr_enter = 1'b1;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase

    // Start or continue a mode-register block at the next present chip select.
    if (mr_enter) begin
      if (np_found) begin
        mr_n = np_idx; st_n = ST_MR1;
      end else if (wl_n) begin
        st_n = ST_ODT_LOAD;
      end else begin
        cs_n = grp_next; st_n = ST_SCAN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cs_ptr <= '0; mr_ptr <= '0; dimm_q <= '0;
      nib_q <= 1'b0; wl_q <= 1'b0; ref_q <= 1'b0; pair_q <= 1'b0; pn_q <= 1'b0;
    end else begin
      state <= st_n; cs_ptr <= cs_n; mr_ptr <= mr_n; dimm_q <= dimm_n;
      nib_q <= nib_n; wl_q <= wl_n; ref_q <= ref_n; pair_q <= pair_n; pn_q <= pn_n;
    end
  end

  assign mr_req_o      = (state == ST_MR1) || (state == ST_MR2);
  assign mr_sel_o      = (state == ST_MR2);
  assign mr_cs_o       = mr_ptr;
  assign mr_wl_o       = wl_q;
  assign odt_load_o    = (state == ST_ODT_LOAD);
  assign seed_req_o    = (state == ST_SEED);
  assign odt_en_o      = (state == ST_ODT_SET) || (state == ST_TRAIN) || (state == ST_POST);
  assign train_en_o    = (state == ST_TRAIN);
  assign post_req_o    = (state == ST_POST);
  assign dimm_o        = dimm_q;
  assign nibble_o      = nib_q;
  assign refresh_off_o = ref_q;
  assign zq_int_o      = ref_q ? ZQ_HOLD : ZQ_NORMAL;
  assign busy_o        = (state != ST_IDLE) && (state != ST_DONE);
  assign done_o        = (state == ST_DONE);
endmodule

// File: rtl/wlvl_seq_chk.sv
module wlvl_seq_chk #(
  parameter int TRAIN_WAIT = 200,
  parameter int CS_W       = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mr_req_o,
  input logic [CS_W-1:0] mr_cs_o,
  input logic            mr_sel_o,
  input logic            mr_ack_i,
  input logic            odt_load_o,
  input logic            seed_req_o,
  input logic            seed_ack_i,
  input logic            odt_en_o,
  input logic            train_en_o,
  input logic            post_req_o,
  input logic            refresh_off_o,
  input logic [1:0]      zq_int_o,
  input logic            busy_o,
  input logic            done_o
);
  int train_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          train_run <= 0;
    else if (train_en_o) train_run <= train_run + 1;
    else                 train_run <= 0;
  end

  assert_mr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mr_req_o && !mr_ack_i |=> mr_req_o && $stable(mr_cs_o) && $stable(mr_sel_o));

  assert_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    odt_load_o |-> !mr_req_o && !odt_en_o && !seed_req_o);

  assert_seed_to_odt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req_o && seed_ack_i |=> odt_en_o);

  assert_train_in_odt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_en_o |-> odt_en_o);

  assert_train_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_en_o |-> train_run < TRAIN_WAIT);

  assert_post_after_train_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_en_o) |-> post_req_o && odt_en_o);

  assert_refresh_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> refresh_off_o && zq_int_o == 2'd0);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !refresh_off_o);
endmodule

bind wlvl_seq wlvl_seq_chk #(.TRAIN_WAIT(TRAIN_WAIT), .CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mr_req_o(mr_req_o), .mr_cs_o(mr_cs_o),
  .mr_sel_o(mr_sel_o), .mr_ack_i(mr_ack_i), .odt_load_o(odt_load_o),
  .seed_req_o(seed_req_o), .seed_ack_i(seed_ack_i), .odt_en_o(odt_en_o),
  .train_en_o(train_en_o), .post_req_o(post_req_o),
  .refresh_off_o(refresh_off_o), .zq_int_o(zq_int_o), .busy_o(busy_o),
  .done_o(done_o)
);

// File: tb/wlvl_seq_bench.sv
module wlvl_seq_bench;
  localparam int CSN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, second = 0, pair = 0, pernib = 0;
  logic [3:0] cur = 0, boot = 0;
  logic [CSN-1:0] en = 0, pres = 0;
  logic mr_ack = 0, seed_ack = 0, post_ack = 0;
  logic mr_req, mr_sel, mr_wl, odt_load, seed_req, odt_en, train_en, post_req;
  logic nib, refresh_off, busy, done;
  logic [2:0] mr_cs, dimm;
  logic [1:0] zq;

  wlvl_seq u_wlvl_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .second_pass_i(second),
    .cur_speed_i(cur), .boot_speed_i(boot), .pair_cs_i(pair),
    .per_nibble_i(pernib), .cs_enable_i(en), .cs_present_i(pres),
    .mr_req_o(mr_req), .mr_cs_o(mr_cs), .mr_sel_o(mr_sel), .mr_wl_o(mr_wl),
    .mr_ack_i(mr_ack), .odt_load_o(odt_load), .seed_req_o(seed_req),
    .seed_ack_i(seed_ack), .odt_en_o(odt_en), .train_en_o(train_en),
    .post_req_o(post_req), .post_ack_i(post_ack), .dimm_o(dimm),
    .nibble_o(nib), .refresh_off_o(refresh_off), .zq_int_o(zq),
    .busy_o(busy), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Responders with configurable latency.
  int lat = 0, mw = 0, sw = 0, pw = 0;
  always @(posedge clk) begin
    if (!rst_n) begin mr_ack <= 0; mw <= 0; end
    else if (mr_ack) mr_ack <= 0;
    else if (mr_req) begin
      if (mw >= lat) begin mr_ack <= 1; mw <= 0; end else mw <= mw + 1;
    end
  end
  always @(posedge clk) begin
    if (!rst_n) begin seed_ack <= 0; sw <= 0; end
    else if (seed_ack) seed_ack <= 0;
    else if (seed_req) begin
      if (sw >= lat + 1) begin seed_ack <= 1; sw <= 0; end else sw <= sw + 1;
    end
  end
  always @(posedge clk) begin
    if (!rst_n) begin post_ack <= 0; pw <= 0; end
    else if (post_ack) post_ack <= 0;
    else if (post_req) begin
      if (pw >= lat) begin post_ack <= 1; pw <= 0; end else pw <= pw + 1;
    end
  end

  // Reference model state: expected handshake tokens.
  int mr_q[$], seed_q[$], post_q[$];
  int cyc = 0, done_cnt = 0, viol = 0;
  int since_load = -1, odt_rise = -1, train_rise = -1, odt_fall = -1;
  bit p_odt = 0, p_train = 0, p_seed = 0, p_mr = 0, p_seed_hs = 0, p_post_hs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        chk(0, "WATCHDOG", "cycles", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      if (busy != refresh_off || (busy && zq != 2'd0) || (!busy && zq != 2'd2) ||
          (train_en && !odt_en)) viol++;
      if (done) begin done_cnt++; odt_fall = -1; end

      if (mr_req && mr_ack) begin
        int act;
        act = {mr_wl, mr_cs, mr_sel};
        if (mr_q.size() == 0) chk(0, "R4", "unexpected mode write", act, -1);
        else begin
          int e;
          e = mr_q.pop_front();
          chk(act == e, "R4/R9", "mode write {wl,cs,sel}", act, e);
        end
      end
      if (seed_req && seed_ack) begin
        int e;
        e = (seed_q.size() != 0) ? seed_q.pop_front() : -1;
        chk(int'(dimm) * 2 + int'(nib) == e, "R3/R9", "seed {dimm,nibble}",
            int'(dimm) * 2 + int'(nib), e);
      end
      if (post_req && post_ack) begin
        int e;
        e = (post_q.size() != 0) ? post_q.pop_front() : -1;
        chk(int'(dimm) * 2 + int'(nib) == e, "R3/R9", "post {dimm,nibble}",
            int'(dimm) * 2 + int'(nib), e);
      end

      if (odt_load) since_load = 0;
      else if (since_load >= 0) since_load++;
      if (seed_req && !p_seed) begin
        chk(since_load == 41, "R5", "seed rise after load", since_load, 41);
        since_load = -1;
      end
      if (odt_en && !p_odt) begin
        chk(p_seed_hs, "R6", "odt rise after seed ack", 0, 1);
        odt_rise = cyc;
      end
      if (train_en && !p_train) begin
        chk(cyc - odt_rise == 10, "R6", "train after odt", cyc - odt_rise, 10);
        train_rise = cyc;
      end
      if (!train_en && p_train) begin
        chk(cyc - train_rise == 200, "R6", "train length", cyc - train_rise, 200);
        chk(post_req && odt_en, "R7", "post with odt at train fall", post_req, 1);
      end
      if (!odt_en && p_odt) begin
        chk(p_post_hs, "R8", "odt fall after post ack", 0, 1);
        odt_fall = cyc;
      end
      if (mr_req && !p_mr && odt_fall >= 0) begin
        chk(cyc - odt_fall == 10, "R8", "odt-off gap", cyc - odt_fall, 10);
        odt_fall = -1;
      end

      p_seed_hs = seed_req && seed_ack;
      p_post_hs = post_req && post_ack;
      p_odt = odt_en; p_train = train_en; p_seed = seed_req; p_mr = mr_req;
    end
  end

  task automatic run_case(input string name, input bit pr, input bit pn,
                          input logic [7:0] e, input logic [7:0] p,
                          input bit sp, input int c, input int b,
                          input int l, input bit again);
    bit runs;
    int step, w;
    runs = !sp || (c > b);
    step = pr ? 2 : 1;
    mr_q.delete(); seed_q.delete(); post_q.delete();
    if (runs) begin
      for (int cs = 0; cs < CSN; cs += step) begin
        int mask;
        mask = (pr ? 3 : 1) << cs;
        if ((int'(e) & mask) != 0) begin
          for (int nb = 0; nb <= (pn ? 1 : 0); nb++) begin
            for (int q = 0; q < CSN; q++)
              if (p[q]) begin mr_q.push_back(16 + q * 2); mr_q.push_back(16 + q * 2 + 1); end
            seed_q.push_back((cs / step) * 2 + nb);
            post_q.push_back((cs / step) * 2 + nb);
          end
          for (int q = 0; q < CSN; q++)
            if (p[q]) begin mr_q.push_back(q * 2); mr_q.push_back(q * 2 + 1); end
        end
      end
    end
    @(negedge clk);
    pair = pr; pernib = pn; en = e; pres = p; second = sp;
    cur = 4'(c); boot = 4'(b); lat = l; done_cnt = 0; viol = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (runs)
      chk(busy && refresh_off && zq == 2'd0, "R10", {name, " busy/refresh after start"},
          {busy, refresh_off, zq}, 7'b1100);
    else
      chk(done && !busy && !mr_req && !refresh_off, "R2", {name, " immediate done on skip"},
          {done, busy, mr_req, refresh_off}, 4'b1000);
    if (again) begin
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done, "R11", {name, " done seen"}, done, 1);
    chk(!busy && !refresh_off && zq == 2'd2, "R10", {name, " restore at done"},
        {busy, refresh_off, zq}, 2);
    @(negedge clk);
    chk(!done, "R11", {name, " done single cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R11", {name, " done count"}, done_cnt, 1);
    chk(mr_q.size() == 0, "R4", {name, " mode writes left"}, mr_q.size(), 0);
    chk(seed_q.size() == 0 && post_q.size() == 0, "R9", {name, " passes left"},
        seed_q.size() + post_q.size(), 0);
    chk(viol == 0, "R10", {name, " per-cycle refresh/zq/odt rule"}, viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mr_req && !seed_req && !post_req && !odt_en && !train_en &&
        !odt_load && !refresh_off && zq == 2'd2, "R1", "reset state",
        {busy, done, mr_req, seed_req, post_req, odt_en, train_en, odt_load, refresh_off},
        0);
    // R3 single-cs groups, one nibble pass
    run_case("c1", 0, 0, 8'b0000_0101, 8'b0000_0101, 0, 0, 0, 0, 0);
    // R3 paired groups (cs5 enables group at cs4 -> dimm 2), R9 two nibbles, R11 restart ignored
    run_case("c2", 1, 1, 8'b0010_0001, 8'b0011_0011, 0, 0, 0, 2, 1);
    // R2 skip: second pass at equal speed
    run_case("c3", 0, 0, 8'b0000_0001, 8'b0000_0001, 1, 3, 3, 0, 0);
    // R2 proceed: second pass at higher speed, top group dimm 3
    run_case("c4", 1, 0, 8'b1000_0000, 8'b1100_0000, 1, 5, 3, 1, 0);
    // R3 no enabled group
    run_case("c5", 0, 1, 8'b0000_0000, 8'b1111_1111, 0, 0, 0, 0, 0);
    // R5 no present chip select
    run_case("c6", 0, 0, 8'b0000_1000, 8'b0000_0000, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule